// File: doc/BRIEF.md
# Serial Clock Pulse Count Guard

This block sits beside the instruction decoder of a serial memory slave. It protects the memory against stray serial clock edges caused by noise. If a glitch adds an edge, the rest of the frame shifts by one bit. An unguarded slave could then commit data to the wrong location.

The guard counts serial clock rising edges while the chip is selected. Counting starts with the edge that carried the start bit. When the chip is deselected, the guard compares the count with the exact frame length that the decoded programming instruction needs in the selected organisation. It issues a one-cycle execute-permit pulse only on an exact match. Non-programming instructions are never blocked.

Both pins are asynchronous. They are synchronised into the system clock domain. The start-detected strobe, the opcode class and the organisation select come from the decoder in the system clock domain.

The control is a four-state machine:
- `ST_IDLE` goes to `ST_WAIT_START` when chip select is high. This is also the cycle in which the counter is cleared.
- `ST_WAIT_START` goes to `ST_COUNT` on the start strobe, which loads the counter with 1. It goes back to `ST_IDLE` if chip select drops first.
- `ST_COUNT` goes to `ST_JUDGE` when chip select goes low. The verdict is registered on that transition.
- `ST_JUDGE` drives the permit from the verdict for one cycle and always returns to `ST_IDLE`.

Top module: `cpg_guard`

## Requirements
- R1: After reset, `exec_ok` is low. No permit is issued while chip select stays low, whatever the serial clock does.
- R2: Counting begins at the `start_seen` strobe, which counts as 1 for the start bit. Serial clock edges before the strobe in the same selection are not counted.
- R3: With `op_class` = 1 (write) and `org_wide` = 0, a permit is issued only when the count at deselection is exactly 20.
- R4: With `op_class` = 1 (write) and `org_wide` = 1, a permit is issued only when the count is exactly 27.
- R5: With `op_class` = 2 (erase) or 3 (erase-all), the required count is 12 when `org_wide` = 0 and 11 when `org_wide` = 1.
- R6: With `op_class` = 4 (write-all), the required count equals the write count for the selected organisation (20 or 27).
- R7: For a programming class, any count above or below the required length yields no permit.
- R8: Any other `op_class` value (0, 5, 6 or 7) is not gated. A permit is issued at deselection whatever the count.
- R9: The counter saturates at 31. A count of 32 or more never matches, even when the excess equals a multiple of 32.
- R10: The permit is high for exactly one system clock cycle after chip select falls. There is no permit for a selection in which no start strobe arrived.
- R11: A rising chip select clears the counter, so nothing carries over from an earlier selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_pin | input | 1 | Chip select pin, active high, asynchronous |
| sclk_pin | input | 1 | Serial clock pin, asynchronous |
| start_seen | input | 1 | One-cycle strobe from the decoder when the start bit is taken |
| op_class | input | 3 | Decoded instruction class (1 write, 2 erase, 3 erase-all, 4 write-all, others ungated) |
| org_wide | input | 1 | Organisation select: 0 byte-wide, 1 word-wide |
| exec_ok | output | 1 | One-cycle execute-permit pulse |

## Verification
The hardest situation to reach is a glitch count that would alias back to a valid length if the counter wrapped. An example is 52 edges in byte-wide write mode, or 59 in word-wide mode. The bench sweeps edge counts around every expected length and adds runs that are 32 edges too long. It covers each class and both organisations, with and without dummy edges before the start strobe. It computes every expected verdict arithmetically from the frame-length formula, with the count saturated at 31.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    // Instruction class encodings delivered by the decoder
    localparam logic [2:0] OPC_WRITE     = 3'd1;
    localparam logic [2:0] OPC_ERASE     = 3'd2;
    localparam logic [2:0] OPC_ERASE_ALL = 3'd3;
    localparam logic [2:0] OPC_WRITE_ALL = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_START = 2'd1,
        ST_COUNT      = 2'd2,
        ST_JUDGE      = 2'd3
    } guard_state_t;

endpackage

// File: rtl/cpg_sync.sv
// Multi-stage synchroniser for an asynchronous pin; also exposes the
// previous synchronised level so the user can detect edges.
module cpg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic level_d
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain   <= '0;
            level_d <= 1'b0;
        end else begin
            chain   <= {chain[STAGES-2:0], pin};
            level_d <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
endmodule

// File: rtl/cpg_pulse_counter.sv
// Saturating up-counter of serial clock pulses.
module cpg_pulse_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     count <= '0;
        else if (clear)                 count <= '0;
        else if (load)                  count <= CNT_ONE;
        else if (inc && count != CNT_MAX) count <= count + CNT_ONE;
    end

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load && inc && count == CNT_MAX) |=> (count == CNT_MAX));

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load) |=> (count >= $past(count)));
endmodule

// File: rtl/cpg_frame_len.sv
// Required frame length per instruction class and organisation.
module cpg_frame_len
    import cpg_pkg::*;
#(
    parameter int CNT_W      = 5,
    parameter int OPC_BITS   = 2,
    parameter int ADDR_NARROW = 9,
    parameter int ADDR_WIDE   = 8,
    parameter int DATA_NARROW = 8,
    parameter int DATA_WIDE   = 16
) (
    input  logic [2:0]       op_class,
    input  logic             org_wide,
    output logic             gated,
    output logic [CNT_W-1:0] len
);
    localparam int WR_NARROW = 1 + OPC_BITS + ADDR_NARROW + DATA_NARROW;
    localparam int WR_WIDE   = 1 + OPC_BITS + ADDR_WIDE + DATA_WIDE;
    localparam int ER_NARROW = 1 + OPC_BITS + ADDR_NARROW;
    localparam int ER_WIDE   = 1 + OPC_BITS + ADDR_WIDE;

    always_comb begin
        gated = 1'b1;
        len   = '0;
        unique case (op_class)
            OPC_WRITE, OPC_WRITE_ALL:
                len = org_wide ? CNT_W'(WR_WIDE) : CNT_W'(WR_NARROW);
            OPC_ERASE, OPC_ERASE_ALL:
                len = org_wide ? CNT_W'(ER_WIDE) : CNT_W'(ER_NARROW);
            default:
                gated = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpg_guard.sv
module cpg_guard
    import cpg_pkg::*;
#(
    parameter int CNT_W       = 5,
    parameter int SYNC_STAGES = 2,
    parameter int OPC_BITS    = 2,
    parameter int ADDR_NARROW = 9,
    parameter int ADDR_WIDE   = 8,
    parameter int DATA_NARROW = 8,
    parameter int DATA_WIDE   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_pin,
    input  logic       sclk_pin,
    input  logic       start_seen,
    input  logic [2:0] op_class,
    input  logic       org_wide,
    output logic       exec_ok
);
    logic cs_q, cs_d, sclk_q, sclk_d;
    logic cs_rise, sclk_rise;
    logic cnt_clear, cnt_load, cnt_inc;
    logic [CNT_W-1:0] cnt;
    logic             gated_now;
    logic [CNT_W-1:0] len_now;
    logic             verdict_q, gated_q;
    logic [CNT_W-1:0] len_q;
    guard_state_t     state, nstate;

    cpg_sync #(.STAGES(SYNC_STAGES)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .pin(cs_pin), .level(cs_q), .level_d(cs_d));

    cpg_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .pin(sclk_pin), .level(sclk_q), .level_d(sclk_d));

    assign cs_rise   = cs_q & ~cs_d;
    assign sclk_rise = sclk_q & ~sclk_d;

    assign cnt_clear = cs_rise;
    assign cnt_load  = (state == ST_WAIT_START) && cs_q && start_seen;
    assign cnt_inc   = (state == ST_COUNT) && cs_q && sclk_rise;

    cpg_pulse_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .load(cnt_load),
        .inc(cnt_inc), .count(cnt));

    cpg_frame_len #(
        .CNT_W(CNT_W), .OPC_BITS(OPC_BITS),
        .ADDR_NARROW(ADDR_NARROW), .ADDR_WIDE(ADDR_WIDE),
        .DATA_NARROW(DATA_NARROW), .DATA_WIDE(DATA_WIDE)
    ) u_len (
        .op_class(op_class), .org_wide(org_wide),
        .gated(gated_now), .len(len_now));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:       if (cs_q) nstate = ST_WAIT_START;
            ST_WAIT_START: if (!cs_q) nstate = ST_IDLE;
                           else if (start_seen) nstate = ST_COUNT;
            ST_COUNT:      if (!cs_q) nstate = ST_JUDGE;
            ST_JUDGE:      nstate = ST_IDLE;
            default:       nstate = ST_IDLE;
        endcase
    end

    // Verdict capture on deselection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verdict_q <= 1'b0;
            gated_q   <= 1'b0;
            len_q     <= '0;
        end else if (state == ST_COUNT && !cs_q) begin
            verdict_q <= !gated_now || (cnt == len_now);
            gated_q   <= gated_now;
            len_q     <= len_now;
        end
    end

    // Outputs
    always_comb begin
        exec_ok = (state == ST_JUDGE) && verdict_q;
    end

    // R10
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_ok |=> !exec_ok);

    // R10
    permit_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_ok |-> !cs_q);

    // R7
    exact_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_ok && gated_q) |-> (cnt == len_q));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_START && cs_q && start_seen && !cs_rise) |=> (cnt == CNT_W'(1)));

    // R11
    select_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (cnt == '0));
endmodule

// File: tb/sim_cpg_guard.sv
module sim_cpg_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_pin = 1'b0;
    logic       sclk_pin = 1'b0;
    logic       start_seen = 1'b0;
    logic [2:0] op_class = 3'd0;
    logic       org_wide = 1'b0;
    logic       exec_ok;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cpg_guard u0 (
        .clk(clk), .rst_n(rst_n), .cs_pin(cs_pin), .sclk_pin(sclk_pin),
        .start_seen(start_seen), .op_class(op_class), .org_wide(org_wide),
        .exec_ok(exec_ok));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int req_len(input int org, input int op);
        if (op == 1 || op == 4) return (org != 0) ? 1 + 2 + 8 + 16 : 1 + 2 + 9 + 8;
        if (op == 2 || op == 3) return (org != 0) ? 1 + 2 + 8 : 1 + 2 + 9;
        return -1;
    endfunction

    function automatic string tag_of(input int org, input int op, input int n, input int lead);
        string t;
        if (op == 1) t = (org != 0) ? "R4" : "R3";
        else if (op == 2 || op == 3) t = "R5";
        else if (op == 4) t = "R6";
        else t = "R8";
        if (req_len(org, op) > 0 && n != req_len(org, op)) t = {t, "/R7"};
        if (n > 31) t = {t, "/R9"};
        if (lead > 0) t = {t, "/R2"};
        return t;
    endfunction

    task automatic sclk_pulse();
        sclk_pin = 1'b1;
        repeat (4) @(negedge clk);
        sclk_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // n = total pulses from the start bit onward (start bit included)
    task automatic run_frame(input int org, input int op, input int lead,
                             input int n, input bit with_start);
        int pulses = 0;
        int run = 0;
        int maxrun = 0;
        int sat;
        bit ok;
        string tag;
        @(negedge clk);
        org_wide = org[0];
        op_class = op[2:0];
        cs_pin = 1'b1;
        repeat (6) @(negedge clk);
        for (int i = 0; i < lead; i++) sclk_pulse();
        if (with_start) begin
            sclk_pin = 1'b1;
            repeat (4) @(negedge clk);
            sclk_pin = 1'b0;
            repeat (2) @(negedge clk);
            start_seen = 1'b1;
            @(negedge clk);
            start_seen = 1'b0;
            repeat (2) @(negedge clk);
            for (int i = 1; i < n; i++) sclk_pulse();
        end else begin
            for (int i = 0; i < n; i++) sclk_pulse();
        end
        repeat (3) @(negedge clk);
        cs_pin = 1'b0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (exec_ok) begin
                pulses++;
                run++;
                if (run > maxrun) maxrun = run;
            end else run = 0;
        end
        sat = (n > 31) ? 31 : n;
        ok = with_start && (req_len(org, op) < 0 || sat == req_len(org, op));
        tag = with_start ? tag_of(org, op, n, lead) : "R10 no start";
        check(pulses == (ok ? 1 : 0), tag, pulses, ok ? 1 : 0);
        if (ok) check(maxrun == 1, "R10 width", maxrun, 1);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int counts[13] = '{10, 11, 12, 13, 19, 20, 21, 26, 27, 28, 51, 52, 59};
        int seen;
        repeat (3) @(negedge clk);
        check(exec_ok == 1'b0, "R1 in reset", exec_ok, 0);
        rst_n = 1'b1;
        // R1: serial clock activity while deselected gives no permit
        seen = 0;
        op_class = 3'd1;
        for (int i = 0; i < 20; i++) begin
            sclk_pin = 1'b1;
            repeat (4) @(negedge clk);
            if (exec_ok) seen++;
            sclk_pin = 1'b0;
            repeat (4) @(negedge clk);
            if (exec_ok) seen++;
        end
        check(seen == 0, "R1 idle", seen, 0);

        for (int org = 0; org < 2; org++)
            for (int op = 0; op < 5; op++)
                for (int k = 0; k < 13; k++)
                    run_frame(org, op, (k % 3 == 1) ? 2 : 0, counts[k], 1'b1);

        // R8: reserved class values are not gated
        run_frame(0, 5, 0, 7, 1'b1);
        run_frame(1, 7, 1, 40, 1'b1);
        // R10: no start strobe in the selection
        run_frame(0, 1, 0, 20, 1'b0);
        // R11: a short aborted selection followed by an exact write
        run_frame(0, 1, 0, 5, 1'b0);
        run_frame(0, 1, 0, 20, 1'b1);
        // R2: many leading pulses ahead of the start strobe
        run_frame(1, 2, 5, 11, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule